// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block keeps a small direct-mapped, write-back cache coherent with other caches on a shared snooping bus. Each line holds one word and sits in one of three states: invalid (no data), shared (clean copy that may only be read) or exclusive (the only copy, writable and dirty). The CPU side issues reads and writes. Hits complete in the same cycle. Misses request the bus. After grant the controller writes back a dirty conflicting victim if there is one, issues a read miss or a write miss, and fills the line from the memory response.

On the bus side the controller watches transactions from other agents and compares the index and tag of each one against its own line. A foreign write miss invalidates a matching copy. If the matching copy is dirty, the controller also aborts the memory access and supplies the word itself. A foreign read miss that hits a dirty line gets the same abort and data supply, and the line drops to shared. Snoop handling takes priority over a CPU request that is stalled or still waiting for grant. Transactions carrying this agent's own identifier are ignored.

Top module: `cache_coh_ctrl`

## Requirements
- R1: After reset every line is invalid, and bus_req, bus_valid, snp_abort and cpu_ready are low.
- R2: A CPU read to an invalid or non-matching line issues one bus transaction with bus_cmd=1 (read miss) at the requested address, and the line becomes shared. A foreign read miss to it then causes no abort.
- R3: A CPU write to an invalid line, or to a shared line of the same tag, issues one transaction with bus_cmd=2 (write miss), and the line becomes exclusive holding the written word.
- R4: A read that matches a shared or exclusive line, and a write that matches an exclusive line, raise cpu_ready in the cycle of the request and issue no bus transaction.
- R5: A read that conflicts with an exclusive line of a different tag first issues bus_cmd=3 (write-back) carrying the victim's address and data. It then issues a read miss, and the line ends shared.
- R6: A write that conflicts with an exclusive line of a different tag issues a write-back of the victim, then a write miss, and the line ends exclusive.
- R7: A foreign write miss (snp_cmd=2) matching a shared line invalidates it with no abort, so the next read of that address misses.
- R8: A foreign read miss (snp_cmd=1) matching an exclusive line raises snp_abort with the line's data on snp_data in the cycle after the snoop. The line becomes shared: reads still hit, and a write needs a write miss.
- R9: A foreign write miss matching an exclusive line raises snp_abort with the line's data one cycle later and invalidates the line.
- R10: A CPU request that needs the bus holds cpu_ready low and keeps bus_req high. No bus_valid appears before bus_gnt has been seen, and cpu_ready rises only with mem_rvalid.
- R11: A foreign snoop arriving while a miss waits for grant is acted on first. If it removes the dirty victim, no write-back is issued after grant.
- R12: A snoop whose snp_src equals the AGENT_ID parameter (default 0), or whose tag does not match, changes nothing and raises no abort.
- R13: On a read miss, cpu_rdata returns mem_rdata in the cycle cpu_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | CPU word address (low IW bits are the index) |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Transaction issued this cycle |
| bus_cmd | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write-back data |
| mem_rvalid | input | 1 | Memory fill response valid |
| mem_rdata | input | DW | Memory fill data |
| snp_valid | input | 1 | Observed bus transaction valid |
| snp_cmd | input | 2 | Observed command, same coding as bus_cmd |
| snp_addr | input | AW | Observed address |
| snp_src | input | IDW | Issuing agent identifier |
| snp_abort | output | 1 | Abort memory access, this cache supplies data |
| snp_data | output | DW | Dirty data supplied with snp_abort |

## Verification
Several properties are checked on every cycle. Bus transactions start only after a grant has been seen. A write-back is always followed directly by a miss. An abort is traced back to a foreign, non-write-back snoop. The CPU is never released while it holds the bus unless a fill arrives. The state outcomes can only be shown by the bench's scenarios: shared versus exclusive versus invalid after each CPU or snoop event, victim write-back ordering with the right address and data, a snoop overriding a pending miss, and the own-agent and tag-mismatch filters. The bench observes each outcome through later hits, misses and aborts.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        L_INV = 2'd0,
        L_SHD = 2'd1,
        L_EXC = 2'd2
    } lstate_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bcmd_e;

    typedef enum logic [2:0] {
        C_IDLE = 3'd0,
        C_ARB  = 3'd1,
        C_WB   = 3'd2,
        C_MISS = 3'd3,
        C_FILL = 3'd4
    } cstate_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int LINES = 4,
    parameter int TW    = 6,
    parameter int DW    = 8,
    localparam int IW   = $clog2(LINES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  lstate_e        wr_state,
    input  logic [TW-1:0]  wr_tag,
    input  logic [DW-1:0]  wr_data,
    input  logic [IW-1:0]  a_idx,
    output lstate_e        a_state,
    output logic [TW-1:0]  a_tag,
    output logic [DW-1:0]  a_data,
    input  logic [IW-1:0]  b_idx,
    output lstate_e        b_state,
    output logic [TW-1:0]  b_tag,
    output logic [DW-1:0]  b_data
);
    lstate_e       st_arr  [LINES];
    logic [TW-1:0] tag_arr [LINES];
    logic [DW-1:0] dat_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        lstate_e       st_d,  st_q;
        logic [TW-1:0] tag_d, tag_q;
        logic [DW-1:0] dat_d, dat_q;

        always_comb begin
            st_d  = st_q;
            tag_d = tag_q;
            dat_d = dat_q;
            if (wr_en && (wr_idx == IW'(g))) begin
                st_d  = wr_state;
                tag_d = wr_tag;
                dat_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= L_INV;
                tag_q <= '0;
                dat_q <= '0;
            end else begin
                st_q  <= st_d;
                tag_q <= tag_d;
                dat_q <= dat_d;
            end
        end

        assign st_arr[g]  = st_q;
        assign tag_arr[g] = tag_q;
        assign dat_arr[g] = dat_q;
    end

    assign a_state = st_arr[a_idx];
    assign a_tag   = tag_arr[a_idx];
    assign a_data  = dat_arr[a_idx];
    assign b_state = st_arr[b_idx];
    assign b_tag   = tag_arr[b_idx];
    assign b_data  = dat_arr[b_idx];
endmodule

// File: rtl/coh_snoop_eval.sv
module coh_snoop_eval
    import coh_pkg::*;
#(
    parameter int TW       = 6,
    parameter int IDW      = 2,
    parameter int AGENT_ID = 0
) (
    input  logic           snp_valid,
    input  logic [1:0]     snp_cmd,
    input  logic [TW-1:0]  snp_tag,
    input  logic [IDW-1:0] snp_src,
    input  lstate_e        line_state,
    input  logic [TW-1:0]  line_tag,
    output logic           act,
    output logic           upd,
    output lstate_e        new_state,
    output logic           abort
);
    logic hit;

    always_comb begin
        act       = snp_valid && (snp_src != IDW'(AGENT_ID));
        hit       = act && (line_state != L_INV) && (line_tag == snp_tag);
        upd       = 1'b0;
        abort     = 1'b0;
        new_state = line_state;
        if (hit) begin
            if (snp_cmd == BC_RDMISS && line_state == L_EXC) begin
                upd       = 1'b1;
                abort     = 1'b1;
                new_state = L_SHD;
            end else if (snp_cmd == BC_WRMISS) begin
                upd       = 1'b1;
                abort     = (line_state == L_EXC);
                new_state = L_INV;
            end
        end
    end
endmodule

// File: rtl/cache_coh_ctrl.sv
module cache_coh_ctrl
    import coh_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int LINES    = 4,
    parameter int IDW      = 2,
    parameter int AGENT_ID = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_req,
    input  logic           cpu_we,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [DW-1:0]  cpu_wdata,
    output logic [DW-1:0]  cpu_rdata,
    output logic           cpu_ready,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           bus_valid,
    output logic [1:0]     bus_cmd,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic           mem_rvalid,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           snp_valid,
    input  logic [1:0]     snp_cmd,
    input  logic [AW-1:0]  snp_addr,
    input  logic [IDW-1:0] snp_src,
    output logic           snp_abort,
    output logic [DW-1:0]  snp_data
);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW;

    typedef struct packed {
        cstate_e       st;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          abort;
        logic [DW-1:0] sdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IW-1:0] a_idx;
    lstate_e       a_state, b_state;
    logic [TW-1:0] a_tag, b_tag;
    logic [DW-1:0] a_data, b_data;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    lstate_e       wr_state;
    logic [TW-1:0] wr_tag;
    logic [DW-1:0] wr_data;
    logic          sn_act, sn_upd, sn_abort;
    lstate_e       sn_state;
    logic          snoop_en, tag_eq;

    coh_line_store #(.LINES(LINES), .TW(TW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state),
        .wr_tag(wr_tag), .wr_data(wr_data),
        .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
        .b_idx(snp_addr[IW-1:0]), .b_state(b_state), .b_tag(b_tag), .b_data(b_data)
    );

    coh_snoop_eval #(.TW(TW), .IDW(IDW), .AGENT_ID(AGENT_ID)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[AW-1:IW]),
        .snp_src(snp_src), .line_state(b_state), .line_tag(b_tag),
        .act(sn_act), .upd(sn_upd), .new_state(sn_state), .abort(sn_abort)
    );

    assign a_idx = (ctl_q.st == C_IDLE) ? cpu_addr[IW-1:0] : ctl_q.addr[IW-1:0];

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.abort = 1'b0;
        wr_en       = 1'b0;
        wr_idx      = a_idx;
        wr_state    = a_state;
        wr_tag      = a_tag;
        wr_data     = a_data;
        cpu_ready   = 1'b0;
        cpu_rdata   = a_data;
        tag_eq      = 1'b0;
        snoop_en    = (ctl_q.st == C_IDLE) || (ctl_q.st == C_ARB);

        if (snoop_en && sn_act) begin
            if (sn_upd) begin
                wr_en    = 1'b1;
                wr_idx   = snp_addr[IW-1:0];
                wr_state = sn_state;
                wr_tag   = b_tag;
                wr_data  = b_data;
            end
            ctl_d.abort = sn_abort;
            ctl_d.sdata = b_data;
        end else begin
            case (ctl_q.st)
                C_IDLE: if (cpu_req) begin
                    tag_eq = (a_tag == cpu_addr[AW-1:IW]);
                    if (cpu_we && tag_eq && a_state == L_EXC) begin
                        cpu_ready = 1'b1;
                        wr_en     = 1'b1;
                        wr_data   = cpu_wdata;
                    end else if (!cpu_we && tag_eq && a_state != L_INV) begin
                        cpu_ready = 1'b1;
                    end else begin
                        ctl_d.st    = C_ARB;
                        ctl_d.we    = cpu_we;
                        ctl_d.addr  = cpu_addr;
                        ctl_d.wdata = cpu_wdata;
                    end
                end
                C_ARB: if (bus_gnt) begin
                    tag_eq   = (a_tag == ctl_q.addr[AW-1:IW]);
                    ctl_d.st = (a_state == L_EXC && !tag_eq) ? C_WB : C_MISS;
                end
                C_WB:   ctl_d.st = C_MISS;
                C_MISS: ctl_d.st = C_FILL;
                C_FILL: if (mem_rvalid) begin
                    wr_en     = 1'b1;
                    wr_state  = ctl_q.we ? L_EXC : L_SHD;
                    wr_tag    = ctl_q.addr[AW-1:IW];
                    wr_data   = ctl_q.we ? ctl_q.wdata : mem_rdata;
                    cpu_ready = 1'b1;
                    cpu_rdata = mem_rdata;
                    ctl_d.st  = C_IDLE;
                end
                default: ctl_d.st = C_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: C_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_req   = (ctl_q.st != C_IDLE);
    assign bus_valid = (ctl_q.st == C_WB) || (ctl_q.st == C_MISS);
    assign bus_cmd   = (ctl_q.st == C_WB)   ? BC_WBACK :
                       (ctl_q.st == C_MISS) ? (ctl_q.we ? BC_WRMISS : BC_RDMISS) : BC_NONE;
    assign bus_addr  = (ctl_q.st == C_WB) ? {a_tag, ctl_q.addr[IW-1:0]} : ctl_q.addr;
    assign bus_wdata = (ctl_q.st == C_WB) ? a_data : ctl_q.wdata;
    assign snp_abort = ctl_q.abort;
    assign snp_data  = ctl_q.sdata;

    // R10
    grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> $past(bus_gnt));

    // R5
    wb_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == BC_WBACK) |=> (bus_valid && bus_cmd != BC_WBACK));

    // R8
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |-> ($past(snp_valid) && $past(snp_src) != IDW'(AGENT_ID)
                       && $past(snp_cmd) != BC_WBACK));

    // R4
    ready_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    // R10
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && bus_req) |-> mem_rvalid);
endmodule

// File: tb/tb_cache_coh_ctrl.sv
module tb_cache_coh_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8, DW = 8, IDW = 2;

    logic clk = 0, rst_n = 0;
    logic cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
    logic cpu_ready, bus_req, bus_valid;
    logic bus_gnt = 0;
    logic [1:0] bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic mem_rvalid = 0;
    logic [DW-1:0] mem_rdata = '0;
    logic snp_valid = 0;
    logic [1:0] snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic [IDW-1:0] snp_src = '0;
    logic snp_abort;
    logic [DW-1:0] snp_data;

    int tests = 0, fails = 0;
    logic allow_gnt = 1;
    logic mem_pend = 0;
    logic [AW-1:0] pend_addr = '0;
    int log_n = 0;
    logic [1:0] log_cmd [16];
    logic [AW-1:0] log_addr [16];
    logic [DW-1:0] log_data [16];

    cache_coh_ctrl #(.AW(AW), .DW(DW), .LINES(4), .IDW(IDW), .AGENT_ID(0)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_src(snp_src), .snp_abort(snp_abort), .snp_data(snp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return a ^ 8'hA5;
    endfunction

    // arbiter, memory and bus log, all updated away from the active edge
    always @(negedge clk) begin
        bus_gnt = bus_req && allow_gnt;
        if (mem_pend) begin
            mem_rvalid = 1; mem_rdata = mem_val(pend_addr); mem_pend = 0;
        end else begin
            mem_rvalid = 0;
        end
        if (bus_valid) begin
            if (log_n < 16) begin
                log_cmd[log_n] = bus_cmd; log_addr[log_n] = bus_addr; log_data[log_n] = bus_wdata;
            end
            log_n++;
            if (bus_cmd == 2'd1 || bus_cmd == 2'd2) begin
                mem_pend = 1; pend_addr = bus_addr;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_start(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        log_n = 0;
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    endtask

    task automatic cpu_wait(output logic [DW-1:0] rd);
        rd = '0;
        for (int i = 0; i < 60; i++) begin
            #1;
            if (cpu_ready) begin rd = cpu_rdata; break; end
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        cpu_req = 0;
    endtask

    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd);
        cpu_start(we, a, d);
        cpu_wait(rd);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [IDW-1:0] s,
                         output logic ab, output logic [DW-1:0] sd);
        @(negedge clk);
        snp_valid = 1; snp_cmd = c; snp_addr = a; snp_src = s;
        @(negedge clk);
        snp_valid = 0;
        #1;
        ab = snp_abort; sd = snp_data;
    endtask

    task automatic t_reset;
        check(!bus_req && !bus_valid, "R1 bus idle", {bus_req, bus_valid}, 0);
        check(!snp_abort && !cpu_ready, "R1 abort/ready low", {snp_abort, cpu_ready}, 0);
    endtask

    task automatic t_read_miss;
        logic [DW-1:0] rd; logic ab; logic [DW-1:0] sd;
        cpu_op(0, 8'h04, 0, rd);
        check(log_n == 1 && log_cmd[0] == 2'd1 && log_addr[0] == 8'h04, "R2 read miss on bus", log_n, 1);
        check(rd == mem_val(8'h04), "R13 fill data", rd, mem_val(8'h04));
        cpu_op(0, 8'h04, 0, rd);
        check(log_n == 0 && rd == mem_val(8'h04), "R4 read hit shared", log_n, 0);
        snoop(2'd1, 8'h04, 1, ab, sd);
        check(!ab, "R2 shared line no abort", ab, 0);
    endtask

    task automatic t_write;
        logic [DW-1:0] rd;
        cpu_op(1, 8'h04, 8'h3C, rd);
        check(log_n == 1 && log_cmd[0] == 2'd2 && log_addr[0] == 8'h04, "R3 write miss from shared", log_cmd[0], 2);
        cpu_op(0, 8'h04, 0, rd);
        check(log_n == 0 && rd == 8'h3C, "R4 read hit exclusive", rd, 8'h3C);
        cpu_op(1, 8'h04, 8'h77, rd);
        check(log_n == 0, "R4 write hit exclusive", log_n, 0);
    endtask

    task automatic t_conflict_read;
        logic [DW-1:0] rd; logic ab; logic [DW-1:0] sd;
        cpu_op(0, 8'h08, 0, rd);
        check(log_n == 2 && log_cmd[0] == 2'd3 && log_addr[0] == 8'h04 && log_data[0] == 8'h77,
              "R5 victim write-back", log_data[0], 8'h77);
        check(log_cmd[1] == 2'd1 && log_addr[1] == 8'h08 && rd == mem_val(8'h08), "R5 read miss after wb", rd, mem_val(8'h08));
        snoop(2'd1, 8'h08, 1, ab, sd);
        check(!ab, "R5 line ends shared", ab, 0);
    endtask

    task automatic t_conflict_write;
        logic [DW-1:0] rd;
        cpu_op(1, 8'h05, 8'h11, rd);
        check(log_n == 1 && log_cmd[0] == 2'd2, "R3 write miss from invalid", log_n, 1);
        cpu_op(1, 8'h09, 8'h22, rd);
        check(log_n == 2 && log_cmd[0] == 2'd3 && log_addr[0] == 8'h05 && log_data[0] == 8'h11,
              "R6 victim write-back", log_addr[0], 8'h05);
        check(log_cmd[1] == 2'd2 && log_addr[1] == 8'h09, "R6 write miss after wb", log_cmd[1], 2);
        cpu_op(0, 8'h09, 0, rd);
        check(log_n == 0 && rd == 8'h22, "R6 line exclusive", rd, 8'h22);
    endtask

    task automatic t_snoop_wr_shared;
        logic [DW-1:0] rd; logic ab; logic [DW-1:0] sd;
        snoop(2'd2, 8'h08, 1, ab, sd);
        check(!ab, "R7 no abort on shared", ab, 0);
        cpu_op(0, 8'h08, 0, rd);
        check(log_n == 1 && log_cmd[0] == 2'd1, "R7 invalidated line misses", log_n, 1);
    endtask

    task automatic t_snoop_rd_exc;
        logic [DW-1:0] rd; logic ab; logic [DW-1:0] sd;
        snoop(2'd1, 8'h09, 2, ab, sd);
        check(ab && sd == 8'h22, "R8 abort with dirty data", sd, 8'h22);
        cpu_op(0, 8'h09, 0, rd);
        check(log_n == 0 && rd == 8'h22, "R8 still readable", rd, 8'h22);
        cpu_op(1, 8'h09, 8'h33, rd);
        check(log_n == 1 && log_cmd[0] == 2'd2, "R8 write needs write miss", log_n, 1);
    endtask

    task automatic t_snoop_wr_exc;
        logic [DW-1:0] rd; logic ab; logic [DW-1:0] sd;
        snoop(2'd2, 8'h09, 3, ab, sd);
        check(ab && sd == 8'h33, "R9 abort with dirty data", sd, 8'h33);
        cpu_op(0, 8'h09, 0, rd);
        check(log_n == 1 && log_cmd[0] == 2'd1 && rd == mem_val(8'h09), "R9 invalid, no write-back", log_n, 1);
    endtask

    task automatic t_ignore;
        logic [DW-1:0] rd; logic ab; logic [DW-1:0] sd;
        cpu_op(1, 8'h0A, 8'h44, rd);
        snoop(2'd2, 8'h0A, 0, ab, sd);
        check(!ab, "R12 own transaction ignored", ab, 0);
        snoop(2'd2, 8'h0E, 1, ab, sd);
        check(!ab, "R12 tag mismatch ignored", ab, 0);
        cpu_op(0, 8'h0A, 0, rd);
        check(log_n == 0 && rd == 8'h44, "R12 line untouched", rd, 8'h44);
    endtask

    task automatic t_priority;
        logic [DW-1:0] rd; logic ab; logic [DW-1:0] sd;
        allow_gnt = 0;
        cpu_start(0, 8'h06, 0);
        repeat (3) @(negedge clk);
        #1;
        check(bus_req && !bus_valid && !cpu_ready, "R10 stalled without grant",
              {bus_req, bus_valid, cpu_ready}, 3'b100);
        snoop(2'd2, 8'h0A, 1, ab, sd);
        check(ab && sd == 8'h44, "R11 snoop served while waiting", sd, 8'h44);
        allow_gnt = 1;
        cpu_wait(rd);
        check(log_n == 1 && log_cmd[0] == 2'd1 && log_addr[0] == 8'h06, "R11 no write-back after snoop", log_n, 1);
        check(rd == mem_val(8'h06), "R13 fill data after stall", rd, mem_val(8'h06));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        t_reset();
        t_read_miss();
        t_write();
        t_conflict_read();
        t_conflict_write();
        t_snoop_wr_shared();
        t_snoop_rd_exc();
        t_snoop_wr_exc();
        t_ignore();
        t_priority();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule